// File: doc/BRIEF.md
# Attributed Character Cell Pixel Generator

This block is the pixel end of a character-cell video pipeline built from 8x8 cells. For each cell the display logic presents a character code, an attribute byte and the 3-bit glyph row that the current scan line crosses. The block forms the address into an external character generator memory and captures the byte that memory returns. It then reshapes that byte according to the attributes and shifts it out one pixel per pixel enable, together with a background register index.

Attribute bits pick one of four character sets, which form the top bits of the generator address. They can mirror the glyph left-to-right by reversing the fetched byte, or top-to-bottom by inverting the row bits used in the address. They can also fake an underline by inverting the byte of the cell's displayed bottom row. In extended-colour mode the two top code bits become a background register index, and only the six low code bits index glyphs.

The generator memory is a plain synchronous read port: the address is driven while `fetch_i` is high, and the data is expected on `gen_data_i` one clock later. A `load_i` strobe at the cell boundary moves the prepared byte into the pixel shifter.

Top module: `cellpix_gen`

## Requirements
- R1: A synchronous active-high reset clears the pixel output, the background index and the shifter, so pixel enables after reset produce 0 until a load.
- R2: While `fetch_i` is high, `gen_addr_o` equals {set, glyph index, displayed row}, 13 bits wide, with set = attribute bits [1:0] at address bits [12:11] and the glyph index at bits [10:3].
- R3: With `ecm_i` high, the glyph index is {2'b00, code[5:0]} and `bg_o` carries code[7:6] for that cell. With `ecm_i` low, the glyph index is the full code and `bg_o` is 0.
- R4: Attribute bit 3 (vertical mirror) makes the displayed row 7 - row, which is placed in address bits [2:0]. Otherwise the row passes unchanged.
- R5: Attribute bit 2 (horizontal mirror) reverses the bit order of the fetched byte before it reaches the shifter.
- R6: Attribute bit 4 (underline) inverts every bit of the fetched byte when the displayed row (after any vertical mirror) is 7, and has no effect on other rows.
- R7: The byte returned one clock after a fetch is held until `load_i`. The clock edge that samples `load_i` puts the byte's MSB on `pix_o` and the cell's index on `bg_o`. Each later clock edge that samples `pix_en_i` high presents the next bit, MSB first.
- R8: After the eighth pixel has been shown, a further pixel enable drives `pix_o` to 0 until the next load. With neither `pix_en_i` nor `load_i`, `pix_o` and `bg_o` hold.
- R9: Attribute bits [7:5] have no effect on the address or the pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_i | input | 1 | Cell fetch strobe; the address is valid while high |
| code_i | input | 8 | Character code of the cell |
| attr_i | input | 8 | Attribute byte: [1:0] set, [2] horizontal mirror, [3] vertical mirror, [4] underline, [7:5] unused |
| row_i | input | 3 | Glyph row from the row counter |
| ecm_i | input | 1 | Extended-colour mode |
| gen_addr_o | output | 13 | Character generator read address |
| gen_data_i | input | 8 | Generator read data, valid one clock after the address |
| load_i | input | 1 | Cell boundary strobe that loads the shifter |
| pix_en_i | input | 1 | Advance to the next pixel |
| pix_o | output | 1 | Pixel-on bit |
| bg_o | output | 2 | Background register index aligned with `pix_o` |

## Verification
On every cycle, the assertions check how the address is built from set, row and extended-colour code, and the vertical-mirror row inversion. They also check that a load presents the staged MSB, that each pixel enable moves to the next staged bit, the dark output after the eighth pixel, and that the output holds while idle. Only the bench's scenarios can show that the glyph reaches the screen correctly end to end. That covers the bit reversal, the underline falling only on the displayed bottom row (including when it is combined with vertical mirroring), the ignored attribute bits, and the background index following the code's top bits. The bench shows these by comparing the full pixel sequence against its own model of the generator memory.

// File: rtl/cellpix_pkg.sv
package cellpix_pkg;

  // Attribute byte layout; field positions are decoded by the address and glyph stages.
  typedef struct packed {
    logic [2:0] spare;
    logic       underline;
    logic       vmirror;
    logic       hmirror;
    logic [1:0] set;
  } cell_attr_t;

  localparam int ATTR_W = $bits(cell_attr_t);

endpackage

// File: rtl/cellpix_addr.sv
module cellpix_addr
  import cellpix_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int ROW_W  = 3,
  parameter int SET_W  = 2,
  parameter int BG_W   = 2,
  localparam int ADDR_W = SET_W + CODE_W + ROW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_i,
  input  logic [CODE_W-1:0] code_i,
  input  cell_attr_t        attr_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic              ecm_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ctx_valid_o,
  output logic              ctx_hmirror_o,
  output logic              ctx_invert_o,
  output logic [BG_W-1:0]   ctx_bg_o
);

  localparam int IDX_W = CODE_W - BG_W;

  function automatic logic [ROW_W-1:0] shown_row(input logic [ROW_W-1:0] r, input logic vm);
    return vm ? ~r : r;
  endfunction

  function automatic logic [CODE_W-1:0] glyph_index(input logic [CODE_W-1:0] c, input logic ecm);
    return ecm ? {{BG_W{1'b0}}, c[IDX_W-1:0]} : c;
  endfunction

  function automatic logic [BG_W-1:0] bg_index(input logic [CODE_W-1:0] c, input logic ecm);
    return ecm ? c[CODE_W-1 -: BG_W] : '0;
  endfunction

  logic [ROW_W-1:0] row_shown;
  logic             last_row;

  assign row_shown = shown_row(row_i, attr_i.vmirror);
  assign last_row  = (row_shown == {ROW_W{1'b1}});
  assign addr_o    = {attr_i.set[SET_W-1:0], glyph_index(code_i, ecm_i), row_shown};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx_valid_o   <= 1'b0;
      ctx_hmirror_o <= 1'b0;
      ctx_invert_o  <= 1'b0;
      ctx_bg_o      <= '0;
    end else begin
      ctx_valid_o <= fetch_i;
      if (fetch_i) begin
        ctx_hmirror_o <= attr_i.hmirror;
        ctx_invert_o  <= attr_i.underline && last_row;
        ctx_bg_o      <= bg_index(code_i, ecm_i);
      end
    end
  end

endmodule

// File: rtl/cellpix_glyph.sv
module cellpix_glyph #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0] raw_i,
  input  logic             hmirror_i,
  input  logic             invert_i,
  output logic [PIX_W-1:0] shaped_o
);

  function automatic logic [PIX_W-1:0] reverse_bits(input logic [PIX_W-1:0] v);
    logic [PIX_W-1:0] r;
    for (int i = 0; i < PIX_W; i++) r[i] = v[PIX_W-1-i];
    return r;
  endfunction

  logic [PIX_W-1:0] oriented;

  assign oriented = hmirror_i ? reverse_bits(raw_i) : raw_i;
  assign shaped_o = invert_i ? ~oriented : oriented;

endmodule

// File: rtl/cellpix_shift.sv
module cellpix_shift #(
  parameter int PIX_W = 8,
  parameter int BG_W  = 2,
  localparam int CNT_W = $clog2(PIX_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_i,
  input  logic [PIX_W-1:0] cap_data_i,
  input  logic [BG_W-1:0]  cap_bg_i,
  input  logic             load_i,
  input  logic             pix_en_i,
  output logic             pix_o,
  output logic [BG_W-1:0]  bg_o,
  output logic [CNT_W-1:0] left_o,
  output logic             next_bit_o,
  output logic             staged_msb_o
);

  logic [PIX_W-1:0] staged_q;
  logic [BG_W-1:0]  staged_bg_q;
  logic [PIX_W-1:0] sh_q;
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      staged_q    <= '0;
      staged_bg_q <= '0;
    end else if (cap_i) begin
      staged_q    <= cap_data_i;
      staged_bg_q <= cap_bg_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      left_q <= '0;
      pix_o  <= 1'b0;
      bg_o   <= '0;
    end else if (load_i) begin
      sh_q   <= staged_q;
      left_q <= CNT_W'(PIX_W - 1);
      pix_o  <= staged_q[PIX_W-1];
      bg_o   <= staged_bg_q;
    end else if (pix_en_i) begin
      if (left_q != '0) begin
        sh_q   <= sh_q << 1;
        left_q <= left_q - 1'b1;
        pix_o  <= sh_q[PIX_W-2];
      end else begin
        pix_o  <= 1'b0;
      end
    end
  end

  assign left_o       = left_q;
  assign next_bit_o   = sh_q[PIX_W-2];
  assign staged_msb_o = staged_q[PIX_W-1];

endmodule

// File: rtl/cellpix_gen.sv
module cellpix_gen
  import cellpix_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int ROW_W  = 3,
  parameter int SET_W  = 2,
  parameter int BG_W   = 2,
  parameter int PIX_W  = 8,
  localparam int ADDR_W = SET_W + CODE_W + ROW_W,
  localparam int CNT_W  = $clog2(PIX_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [ATTR_W-1:0] attr_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic              ecm_i,
  output logic [ADDR_W-1:0] gen_addr_o,
  input  logic [PIX_W-1:0]  gen_data_i,
  input  logic              load_i,
  input  logic              pix_en_i,
  output logic              pix_o,
  output logic [BG_W-1:0]   bg_o
);

  cell_attr_t       attr_w;
  logic             ctx_valid_w;
  logic             ctx_hmirror_w;
  logic             ctx_invert_w;
  logic [BG_W-1:0]  ctx_bg_w;
  logic [PIX_W-1:0] shaped_w;
  logic [CNT_W-1:0] left_w;
  logic             next_bit_w;
  logic             staged_msb_w;

  assign attr_w = cell_attr_t'(attr_i);

  cellpix_addr #(
    .CODE_W(CODE_W), .ROW_W(ROW_W), .SET_W(SET_W), .BG_W(BG_W)
  ) i_addr (
    .clk(clk), .rst(rst), .fetch_i(fetch_i), .code_i(code_i), .attr_i(attr_w),
    .row_i(row_i), .ecm_i(ecm_i), .addr_o(gen_addr_o), .ctx_valid_o(ctx_valid_w),
    .ctx_hmirror_o(ctx_hmirror_w), .ctx_invert_o(ctx_invert_w), .ctx_bg_o(ctx_bg_w)
  );

  cellpix_glyph #(.PIX_W(PIX_W)) i_glyph (
    .raw_i(gen_data_i), .hmirror_i(ctx_hmirror_w), .invert_i(ctx_invert_w),
    .shaped_o(shaped_w)
  );

  cellpix_shift #(.PIX_W(PIX_W), .BG_W(BG_W)) i_shift (
    .clk(clk), .rst(rst), .cap_i(ctx_valid_w), .cap_data_i(shaped_w),
    .cap_bg_i(ctx_bg_w), .load_i(load_i), .pix_en_i(pix_en_i), .pix_o(pix_o),
    .bg_o(bg_o), .left_o(left_w), .next_bit_o(next_bit_w), .staged_msb_o(staged_msb_w)
  );

endmodule

// File: rtl/cellpix_chk.sv
module cellpix_chk #(
  parameter int CODE_W = 8,
  parameter int ROW_W  = 3,
  parameter int SET_W  = 2,
  parameter int BG_W   = 2,
  parameter int PIX_W  = 8,
  parameter int ATTR_W = 8,
  localparam int ADDR_W = SET_W + CODE_W + ROW_W,
  localparam int CNT_W  = $clog2(PIX_W + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_i,
  input logic [ATTR_W-1:0] attr_i,
  input logic [ROW_W-1:0]  row_i,
  input logic              ecm_i,
  input logic [ADDR_W-1:0] gen_addr_o,
  input logic              load_i,
  input logic              pix_en_i,
  input logic              pix_o,
  input logic [BG_W-1:0]   bg_o,
  input logic [CNT_W-1:0]  left_w,
  input logic              next_bit_w,
  input logic              staged_msb_w
);

  a_r1_reset_dark: assert property (@(posedge clk) rst |=> (!pix_o && bg_o == '0 && left_w == '0));

  a_r2_set_field: assert property (@(posedge clk) disable iff (rst)
    fetch_i |-> gen_addr_o[ADDR_W-1 -: SET_W] == attr_i[SET_W-1:0]);

  a_r3_ecm_index: assert property (@(posedge clk) disable iff (rst)
    (fetch_i && ecm_i) |-> gen_addr_o[ROW_W+CODE_W-1 -: BG_W] == '0);

  a_r4_row_field: assert property (@(posedge clk) disable iff (rst)
    fetch_i |-> (gen_addr_o[ROW_W-1:0] == (attr_i[3] ? ~row_i : row_i)));

  a_r7_load_msb: assert property (@(posedge clk) disable iff (rst)
    load_i |=> pix_o == $past(staged_msb_w));

  a_r7_shift_next: assert property (@(posedge clk) disable iff (rst)
    (pix_en_i && !load_i && left_w != '0) |=> pix_o == $past(next_bit_w));

  a_r8_dark_after_cell: assert property (@(posedge clk) disable iff (rst)
    (pix_en_i && !load_i && left_w == '0) |=> !pix_o);

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!pix_en_i && !load_i) |=> ($stable(pix_o) && $stable(bg_o)));

endmodule

bind cellpix_gen cellpix_chk #(
  .CODE_W(CODE_W), .ROW_W(ROW_W), .SET_W(SET_W), .BG_W(BG_W), .PIX_W(PIX_W),
  .ATTR_W(cellpix_pkg::ATTR_W)
) i_cellpix_chk (
  .clk(clk), .rst(rst), .fetch_i(fetch_i), .attr_i(attr_i), .row_i(row_i),
  .ecm_i(ecm_i), .gen_addr_o(gen_addr_o), .load_i(load_i), .pix_en_i(pix_en_i),
  .pix_o(pix_o), .bg_o(bg_o), .left_w(left_w), .next_bit_w(next_bit_w),
  .staged_msb_w(staged_msb_w)
);

// File: tb/test_cellpix_gen.sv
`timescale 1ns/1ps
module test_cellpix_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch = 1'b0;
  logic [7:0]  code = '0;
  logic [7:0]  attr = '0;
  logic [2:0]  row = '0;
  logic        ecm = 1'b0;
  logic [12:0] addr;
  logic [7:0]  rdata = '0;
  logic        load = 1'b0;
  logic        pen = 1'b0;
  logic        pix;
  logic [1:0]  bg;
  int          total = 0;
  int          bad = 0;

  always #2 clk = ~clk;

  cellpix_gen i_cellpix_gen (
    .clk(clk), .rst(rst), .fetch_i(fetch), .code_i(code), .attr_i(attr), .row_i(row),
    .ecm_i(ecm), .gen_addr_o(addr), .gen_data_i(rdata), .load_i(load), .pix_en_i(pen),
    .pix_o(pix), .bg_o(bg)
  );

  function automatic logic [7:0] rom(input logic [12:0] a);
    return 8'((a * 13'd157) ^ (a >> 5) ^ 13'h5A);
  endfunction

  always @(posedge clk) rdata <= rom(addr);

  function automatic logic [2:0] exp_row(input logic [2:0] r, input logic [7:0] at);
    return at[3] ? 3'd7 - r : r;
  endfunction

  function automatic logic [12:0] exp_addr(input logic [7:0] c, input logic [7:0] at,
                                           input logic [2:0] r, input logic e);
    logic [7:0] idx;
    idx = e ? {2'b00, c[5:0]} : c;
    return {at[1:0], idx, exp_row(r, at)};
  endfunction

  function automatic logic [7:0] exp_byte(input logic [7:0] c, input logic [7:0] at,
                                          input logic [2:0] r, input logic e);
    logic [7:0] b, m;
    b = rom(exp_addr(c, at, r, e));
    if (at[2]) begin
      for (int i = 0; i < 8; i++) m[7-i] = b[i];
      b = m;
    end
    if (at[4] && exp_row(r, at) == 3'd7) b = ~b;
    return b;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_cell(input logic [7:0] c, input logic [7:0] at,
                          input logic [2:0] r, input logic e);
    logic [7:0] eb;
    string      tag;
    eb  = exp_byte(c, at, r, e);
    tag = (at[4] && exp_row(r, at) == 3'd7) ? "R6" : (at[2] ? "R5" : "R7");
    @(negedge clk);
    fetch = 1'b1; code = c; attr = at; row = r; ecm = e;
    #1;
    chk(e ? "R3 addr" : (at[3] ? "R4 addr" : "R2 addr"), int'(addr), int'(exp_addr(c, at, r, e)));
    @(negedge clk);
    fetch = 1'b0;
    code = 8'($urandom); attr = 8'($urandom); row = 3'($urandom);
    @(negedge clk);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    chk({tag, " pixel0"}, int'(pix), int'(eb[7]));
    chk("R3 bg", int'(bg), e ? int'(c[7:6]) : 0);
    for (int k = 1; k < 8; k++) begin
      pen = 1'b1;
      @(negedge clk);
      pen = 1'b0;
      chk({tag, " pixel"}, int'(pix), int'(eb[7-k]));
    end
    @(negedge clk);
    chk("R8 hold", int'(pix), int'(eb[0]));
    pen = 1'b1;
    @(negedge clk);
    pen = 1'b0;
    chk("R8 dark after eighth", int'(pix), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R0 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset pix", int'(pix), 0);
    chk("R1 reset bg", int'(bg), 0);
    rst = 1'b0;
    pen = 1'b1;
    @(negedge clk);
    pen = 1'b0;
    chk("R1 empty shifter", int'(pix), 0);
    // directed corners
    run_cell(8'h41, 8'h00, 3'd0, 1'b0);
    run_cell(8'hC1, 8'h03, 3'd5, 1'b0);   // R2 top set
    run_cell(8'hC1, 8'h01, 3'd5, 1'b1);   // R3 ecm
    run_cell(8'h12, 8'h08, 3'd2, 1'b0);   // R4 vmirror
    run_cell(8'h12, 8'h04, 3'd2, 1'b0);   // R5 hmirror
    run_cell(8'h33, 8'h10, 3'd7, 1'b0);   // R6 underline on row 7
    run_cell(8'h33, 8'h10, 3'd6, 1'b0);   // R6 no effect on row 6
    run_cell(8'h33, 8'h18, 3'd0, 1'b0);   // R6 displayed row 7 via vmirror
    run_cell(8'h33, 8'h18, 3'd7, 1'b0);   // R6 displayed row 0
    run_cell(8'h77, 8'hE2, 3'd3, 1'b1);   // R9 spare bits set
    for (int n = 0; n < 80; n++)
      run_cell(8'($urandom), 8'($urandom), 3'($urandom), 1'($urandom));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule